// File: doc/BRIEF.md
# Serial Memory Write-Protection Acknowledge Controller

This block guards the lower part of a small serial memory against writes and decides, byte by byte, whether a write-type bus transfer is accepted. The bus framing logic tells it which kind of instruction arrived: a memory write, a set-protect, a permanent-set-protect or a clear-protect. It also passes the target address and one strobe per byte phase (instruction, address, data), plus a strobe at the stop condition. For each phase strobe the block answers with an acknowledge or a refusal one clock later. At the stop it issues a one-cycle pulse that starts the internal write cycle, but only when every byte of the transfer was acknowledged.

The block keeps one of three protection states: open, soft-protected (can be undone) and locked (permanent). The acknowledge pattern itself tells the host which state is active. A protected write to the low region is accepted through the address byte and refused at the data byte. A protection command that the current state does not allow is refused from the very first byte.

A new protection state only takes effect when its write cycle ends. The write cycle lasts a fixed number of clocks. While it runs, every byte of every new transfer is refused.

Top module: `wp_ack_ctrl`

## Requirements
- R1: After reset `ack_vld_o` and `wc_start_o` are low. The state is open, or locked if `nv_perm_i` is high while reset is asserted.
- R2: Each strobe on `ins_stb_i`, `adr_stb_i` or `dat_stb_i` makes `ack_vld_o` high for exactly the next clock, carrying the decision on `ack_o` (1 = acknowledge). Strobes are never raised together.
- R3: In the open state, every instruction kind is acknowledged on every byte. Instruction codes on `op_i`: 2'b00 memory write, 2'b01 set-protect, 2'b10 permanent-set-protect, 2'b11 clear-protect. A write cycle then starts at stop.
- R4: In the soft-protected or locked state, a memory write to an address below `PROT_LIMIT` (default 128) is acknowledged on the instruction and address bytes. It is refused on its data bytes, and no write cycle starts.
- R5: A memory write to an address at or above `PROT_LIMIT` is acknowledged on all bytes and starts a write cycle in every state.
- R6: In the soft-protected state, set-protect is refused on all bytes. Clear-protect and permanent-set-protect are acknowledged on all bytes and start a write cycle.
- R7: In the locked state, set-protect, permanent-set-protect and clear-protect are refused on all bytes, and no write cycle starts.
- R8: Once one byte of a transfer is refused, every later byte of that transfer is refused. `wc_start_o` pulses one clock after `stop_i` only if the last data byte was acknowledged.
- R9: `wc_start_o` is a single-cycle pulse. For `WC_CYC` clocks after it, every byte strobe is refused.
- R10: When the write cycle ends, the new state takes effect: set-protect gives soft-protected, clear-protect gives open, and permanent-set-protect gives locked, which nothing leaves except a reset with `nv_perm_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nv_perm_i | input | 1 | Non-volatile lock flag, loaded into the state during reset |
| op_i | input | 2 | Instruction kind, valid with `ins_stb_i` |
| addr_i | input | ADDR_W | Target byte address, valid with `adr_stb_i` |
| ins_stb_i | input | 1 | Instruction byte received |
| adr_stb_i | input | 1 | Address byte received |
| dat_stb_i | input | 1 | Data byte received |
| stop_i | input | 1 | Stop condition seen |
| ack_vld_o | output | 1 | Decision valid for the previous strobe |
| ack_o | output | 1 | 1 = acknowledge, 0 = refuse |
| wc_start_o | output | 1 | One-cycle internal write-cycle start |

## Verification
Each instruction kind is sent in each of the three states, so the state is read back from the acknowledge pattern alone. Memory writes go to addresses on both sides of the protection limit. This separates the address-dependent data refusal from the command refusal that hits the first byte. A two-byte page write in a protected state shows that a refusal carries over to later bytes. A transfer sent right after a write-cycle start shows the busy refusal. Resets with the lock flag high and low show how the state is loaded.

// File: rtl/wp_pkg.sv
package wp_pkg;

   typedef enum logic [1:0] {
      WP_OPEN = 2'd0,
      WP_SOFT = 2'd1,
      WP_LOCK = 2'd2
   } wp_state_e;

   typedef enum logic [1:0] {
      OP_MEM  = 2'b00,
      OP_SET  = 2'b01,
      OP_PERM = 2'b10,
      OP_CLR  = 2'b11
   } wp_op_e;

   typedef enum logic [1:0] {
      PH_INS = 2'd0,
      PH_ADR = 2'd1,
      PH_DAT = 2'd2
   } wp_phase_e;

   // state reached once a write cycle for this instruction finishes
   function automatic wp_state_e wp_next(input wp_state_e cur, input wp_op_e op);
      wp_state_e nxt;
      nxt = cur;
      if (cur != WP_LOCK) begin
         case (op)
            OP_SET:  nxt = WP_SOFT;
            OP_PERM: nxt = WP_LOCK;
            OP_CLR:  nxt = WP_OPEN;
            default: nxt = cur;
         endcase
      end
      return nxt;
   endfunction

   // is the instruction itself allowed in this state
   function automatic logic wp_cmd_ok(input wp_state_e cur, input wp_op_e op);
      logic ok;
      case (op)
         OP_MEM:  ok = 1'b1;
         OP_SET:  ok = (cur == WP_OPEN);
         default: ok = (cur != WP_LOCK);
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/wp_state_reg.sv
module wp_state_reg
   import wp_pkg::*;
#(
   parameter int WC_CYC = 20,
   localparam int CW = $clog2(WC_CYC + 1)
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      nv_perm_i,
   input  logic      wc_go_i,
   input  wp_op_e    op_i,
   output wp_state_e state_o,
   output logic      busy_o
);

   if (WC_CYC < 1) begin : g_bad_wc
      $error("WC_CYC must be at least 1");
   end

   wp_state_e     state_q;
   wp_op_e        pend_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= nv_perm_i ? WP_LOCK : WP_OPEN;
         pend_q  <= OP_MEM;
         cnt_q   <= '0;
      end else if (wc_go_i) begin
         pend_q <= op_i;
         cnt_q  <= CW'(WC_CYC);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CW'(1)) state_q <= wp_next(state_q, pend_q);
      end
   end

   assign state_o = state_q;
   assign busy_o  = (cnt_q != '0);

   // R9
   wc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wc_go_i |-> !busy_o);

   // R10
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == WP_LOCK |=> state_o == WP_LOCK);

endmodule

// File: rtl/wp_ack_decide.sv
module wp_ack_decide
   import wp_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int PROT_LIMIT = 128
) (
   input  wp_state_e         state_i,
   input  logic              busy_i,
   input  logic              alive_i,
   input  wp_phase_e         phase_i,
   input  wp_op_e            op_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              ack_o
);

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_aw
      $error("ADDR_W out of range");
   end
   if (PROT_LIMIT < 0 || PROT_LIMIT > (1 << ADDR_W)) begin : g_bad_lim
      $error("PROT_LIMIT outside address space");
   end

   logic cmd_ok;
   logic high_addr;
   logic data_ok;

   always_comb begin
      cmd_ok    = wp_cmd_ok(state_i, op_i);
      high_addr = (32'(addr_i) >= PROT_LIMIT);
      if (op_i == OP_MEM) data_ok = (state_i == WP_OPEN) || high_addr;
      else                data_ok = cmd_ok;
      if (busy_i) begin
         ack_o = 1'b0;
      end else begin
         case (phase_i)
            PH_INS:  ack_o = cmd_ok;
            PH_ADR:  ack_o = alive_i && cmd_ok;
            default: ack_o = alive_i && data_ok;
         endcase
      end
   end

endmodule

// File: rtl/wp_ack_ctrl.sv
module wp_ack_ctrl
   import wp_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int PROT_LIMIT = 128,
   parameter int WC_CYC     = 20,
   parameter bit ACK_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nv_perm_i,
   input  logic [1:0]        op_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              ins_stb_i,
   input  logic              adr_stb_i,
   input  logic              dat_stb_i,
   input  logic              stop_i,
   output logic              ack_vld_o,
   output logic              ack_o,
   output logic              wc_start_o
);

   wp_state_e         state;
   logic              busy;
   wp_op_e            op_q;
   wp_op_e            op_sel;
   logic [ADDR_W-1:0] addr_q;
   logic              alive_q;
   logic              armed_q;
   logic              any_stb;
   wp_phase_e         phase;
   logic              dec_ack;
   logic              wc_go;
   logic              wc_q;

   assign any_stb = ins_stb_i | adr_stb_i | dat_stb_i;
   assign phase   = ins_stb_i ? PH_INS : (adr_stb_i ? PH_ADR : PH_DAT);
   assign op_sel  = ins_stb_i ? wp_op_e'(op_i) : op_q;
   assign wc_go   = stop_i && armed_q && !busy;

   wp_state_reg #(.WC_CYC(WC_CYC)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .nv_perm_i (nv_perm_i),
      .wc_go_i   (wc_go),
      .op_i      (op_q),
      .state_o   (state),
      .busy_o    (busy)
   );

   wp_ack_decide #(.ADDR_W(ADDR_W), .PROT_LIMIT(PROT_LIMIT)) u_dec (
      .state_i (state),
      .busy_i  (busy),
      .alive_i (alive_q),
      .phase_i (phase),
      .op_i    (op_sel),
      .addr_i  (addr_q),
      .ack_o   (dec_ack)
   );

   // transfer tracking: instruction, address, liveness, arming
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q    <= OP_MEM;
         addr_q  <= '0;
         alive_q <= 1'b0;
         armed_q <= 1'b0;
         wc_q    <= 1'b0;
      end else begin
         wc_q <= wc_go;
         if (ins_stb_i) begin
            op_q    <= wp_op_e'(op_i);
            alive_q <= dec_ack;
            armed_q <= 1'b0;
         end else if (adr_stb_i) begin
            addr_q  <= addr_i;
            alive_q <= alive_q && dec_ack;
         end else if (dat_stb_i) begin
            alive_q <= alive_q && dec_ack;
            armed_q <= alive_q && dec_ack;
         end else if (stop_i) begin
            alive_q <= 1'b0;
            armed_q <= 1'b0;
         end
      end
   end

   assign wc_start_o = wc_q;

   if (ACK_REG) begin : g_ack_reg
      logic vld_q;
      logic ack_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            ack_q <= 1'b0;
         end else begin
            vld_q <= any_stb;
            ack_q <= any_stb && dec_ack;
         end
      end
      assign ack_vld_o = vld_q;
      assign ack_o     = ack_q;

      // R2
      vld_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ack_vld_o |-> $past(any_stb));

      // R9
      busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(busy) && ack_vld_o |-> !ack_o);

      // R8
      dead_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !alive_q && (adr_stb_i || dat_stb_i) |=> !ack_o);

      // R4
      low_data_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
         dat_stb_i && state != WP_OPEN && op_q == OP_MEM && 32'(addr_q) < PROT_LIMIT
         |=> ack_vld_o && !ack_o);
   end else begin : g_ack_comb
      assign ack_vld_o = any_stb;
      assign ack_o     = any_stb && dec_ack;
   end

   // R2
   stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ins_stb_i, adr_stb_i, dat_stb_i, stop_i}));

   // R9
   wc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wc_start_o |=> !wc_start_o);

   // R8
   wc_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wc_start_o |-> $past(stop_i && armed_q));

endmodule

// File: tb/sim_wp_ack_ctrl.sv
module sim_wp_ack_ctrl;

   localparam int AW  = 8;
   localparam int LIM = 128;
   localparam int WC  = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          nv_perm = 1'b0;
   logic [1:0]    op = 2'b00;
   logic [AW-1:0] addr = '0;
   logic          ins_stb = 1'b0, adr_stb = 1'b0, dat_stb = 1'b0, stop = 1'b0;
   logic          ack_vld, ack, wc_start;

   int n_run  = 0;
   int n_fail = 0;
   int m_state = 0;   // 0 open, 1 soft, 2 locked
   bit done = 1'b0;

   bit    exp_q[$];
   string tag_q[$];
   bit    wexp_q[$];
   string wtag_q[$];
   logic  stb_seen = 1'b0, stop_seen = 1'b0;

   always #10 clk = ~clk;

   wp_ack_ctrl #(.ADDR_W(AW), .PROT_LIMIT(LIM), .WC_CYC(WC)) u0 (
      .clk(clk), .rst_n(rst_n), .nv_perm_i(nv_perm), .op_i(op), .addr_i(addr),
      .ins_stb_i(ins_stb), .adr_stb_i(adr_stb), .dat_stb_i(dat_stb), .stop_i(stop),
      .ack_vld_o(ack_vld), .ack_o(ack), .wc_start_o(wc_start));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard as results appear
   always @(posedge clk) begin
      stb_seen  <= ins_stb | adr_stb | dat_stb;
      stop_seen <= stop;
   end

   always @(negedge clk) begin
      if (rst_n && stb_seen && exp_q.size() > 0) begin
         bit e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(ack_vld === 1'b1 && ack === e, t, {ack_vld, ack}, {1'b1, e});
      end
      if (rst_n && stop_seen && wexp_q.size() > 0) begin
         bit e;
         string t;
         e = wexp_q.pop_front();
         t = wtag_q.pop_front();
         check(wc_start === e, t, wc_start, e);
      end
   end

   function automatic bit cmd_ok(input int o);
      if (o == 0) return 1'b1;
      if (o == 1) return m_state == 0;
      return m_state != 2;
   endfunction

   task automatic pulse(input int ph, input bit e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      case (ph)
         0: ins_stb = 1'b1;
         1: adr_stb = 1'b1;
         default: dat_stb = 1'b1;
      endcase
      @(negedge clk);
      ins_stb = 1'b0; adr_stb = 1'b0; dat_stb = 1'b0;
   endtask

   // driver: one write-type transfer, expectations from the requirements
   task automatic xfer(input int o, input int a, input int ndata, input bit busy_now,
                       input bit hold, input string tag);
      bit alive, e, wc;
      op = 2'(o);
      e = !busy_now && cmd_ok(o);
      pulse(0, e, tag);
      alive = e;
      addr = AW'(a);
      e = alive && !busy_now && cmd_ok(o);
      pulse(1, e, tag);
      alive = e;
      for (int i = 0; i < ndata; i++) begin
         if (o == 0) e = alive && !busy_now && (m_state == 0 || a >= LIM);
         else        e = alive && !busy_now && cmd_ok(o);
         pulse(2, e, tag);
         alive = e;
      end
      wc = alive && !busy_now;
      wexp_q.push_back(wc);
      wtag_q.push_back(tag);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      if (wc) begin
         if (o == 1) m_state = 1;
         if (o == 2) m_state = 2;
         if (o == 3) m_state = 0;
         if (!hold) repeat (WC + 2) @(negedge clk);
      end else begin
         @(negedge clk);
      end
   endtask

   task automatic do_reset(input bit nv);
      rst_n = 1'b0;
      nv_perm = nv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_state = nv ? 2 : 0;
      @(negedge clk);
   endtask

   initial begin
      do_reset(1'b0);
      // R1 outputs quiet after reset
      check(ack_vld === 1'b0, "R1 ack_vld", ack_vld, 0);
      check(wc_start === 1'b0, "R1 wc_start", wc_start, 0);
      // R3 open state: everything accepted
      xfer(0, 8'h10, 2, 0, 0, "R3 open low write");
      xfer(3, 8'h00, 1, 0, 0, "R3 open clear");
      xfer(0, 8'h90, 1, 0, 0, "R5 open high write");
      xfer(1, 8'h00, 1, 0, 0, "R10 set to soft");
      // R4 / R5 / R6 in soft state
      xfer(0, 8'h10, 1, 0, 0, "R4 soft low write");
      xfer(0, 8'h7F, 2, 0, 0, "R8 soft page write");
      xfer(0, 8'h80, 1, 0, 0, "R5 soft boundary write");
      xfer(1, 8'h00, 1, 0, 0, "R6 soft repeat set");
      xfer(3, 8'h00, 1, 0, 0, "R6 soft clear");
      xfer(0, 8'h10, 1, 0, 0, "R10 open after clear");
      // R9 busy refusal right after a start
      xfer(1, 8'h00, 1, 0, 1, "R3 open set");
      xfer(0, 8'hA0, 1, 1, 0, "R9 busy refuse");
      repeat (WC + 2) @(negedge clk);
      xfer(2, 8'h00, 1, 0, 0, "R6 soft perm set");
      // R7 locked state
      xfer(1, 8'h00, 1, 0, 0, "R7 locked set");
      xfer(2, 8'h00, 1, 0, 0, "R7 locked perm");
      xfer(3, 8'h00, 1, 0, 0, "R7 locked clear");
      xfer(0, 8'h05, 1, 0, 0, "R4 locked low write");
      xfer(0, 8'hFF, 1, 0, 0, "R5 locked high write");
      // R1 reset loads lock flag
      do_reset(1'b1);
      xfer(3, 8'h00, 1, 0, 0, "R1 reset locked");
      do_reset(1'b0);
      xfer(0, 8'h20, 1, 0, 0, "R1 reset open");
      xfer(2, 8'h00, 1, 0, 0, "R3 open perm set");
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0 && wexp_q.size() == 0, "R2 scoreboard drained",
            exp_q.size() + wexp_q.size(), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule